// File: doc/BRIEF.md
# Second-Order Single-Bit Sigma-Delta Modulator

This block is a synthesizable digital model of a second-order, one-bit sigma-delta modulator. It takes a signed input word standing for a differential voltage and, on each enabled rising clock edge, emits one bit. Over a long run, the fraction of ones in that bit stream tracks the input linearly. It serves as a stimulus source for decimation filters inside a larger chip or test environment.

The loop has two cascaded integrators. A single comparator quantizes the second integrator, and its decision is fed back into both integrators as plus or minus full scale. The same clock both samples the input and frames the output bit. A bit launched on one rising edge is meant to be captured by the consumer on the next rising edge.

The input word is treated as a continuously sampled level, so it has no handshake. The clock enable is the only pacing control. Holding the enable low stalls the modulator completely and applies no back-pressure to anything upstream. A low enable keeps the integrators and the output exactly as they are.

Top module: `sdm2_modulator`

## Requirements
- R1: On each enabled edge, the first integrator adds (input − feedback) and the second adds (new first-integrator value − feedback). Feedback is +32768 when bit_o is 1 and −32768 when it is 0. The new bit_o is 1 when the new second-integrator value is ≥ 0. From reset with input 0, the first four bits are 1, 1, 0, 1.
- R2: A constant input of 0 gives 2048 ± 20 ones in any 4096-bit window after 64 settling cycles.
- R3: A constant input of +20480 (0.625 of full scale) gives 3328 ± 20 ones per 4096 bits, which is 81.25 %.
- R4: A constant input of −20480 gives 768 ± 20 ones per 4096 bits (18.75 %). Together with the R3 count, the two totals sum to 4096 ± 16.
- R5: An input of +32767 gives at least 4076 ones per 4096 bits. An input of −32768 gives at most 20 ones.
- R6: Integrators are 4 bits wider than the input and saturate instead of wrapping. After 64 settling cycles under constant full-scale drive, the 4096-bit window is all ones for +32767 and all zeros for −32768.
- R7: A synchronous reset (srst_i high at a rising edge) clears both integrators and drives bit_o to 0, whatever the state of ce_i. The following bits then repeat the R1 start-up sequence.
- R8: While ce_i is low, bit_o and both integrators hold, and sample_i has no effect. After the enable returns, the stream continues exactly where it stopped.
- R9: bit_o changes only just after a rising clock edge and stays stable until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Modulator clock; sampling and output framing clock |
| srst_i | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Clock enable; low holds all state |
| sample_i | input | IN_W (16) | Signed two's-complement input level |
| bit_o | output | 1 | Serial modulator bit, launched on the rising edge |

## Verification
Corrupted integrator state shows at the ports in one of two ways. It can distort the start-up bit pattern within the first four enabled cycles. It can also shift the ones count of a 4096-bit window by far more than the 20-count tolerance. A missing saturation produces a wrap, which shows up as stray zeros under positive full-scale drive (or stray ones under negative drive) within a few dozen cycles. A hold or reset fault changes the bits that follow the enable or reset event directly, so it appears within one to four clocks.

// File: rtl/sdm2_pkg.sv
package sdm2_pkg;
  // Default input word width and integrator headroom.
  localparam int unsigned DEF_IN_W  = 16;
  localparam int unsigned DEF_GUARD = 4;

  // Which way an integrator update was clamped, if at all.
  typedef enum logic [1:0] {
    SAT_NONE = 2'b00,
    SAT_HIGH = 2'b01,
    SAT_LOW  = 2'b10
  } sat_e;
endpackage

// File: rtl/sdm2_integrator.sv
module sdm2_integrator #(
  parameter int unsigned ACC_W = 20
) (
  input  logic                    clk_i,
  input  logic                    srst_i,
  input  logic                    ce_i,
  input  logic signed [ACC_W-1:0] addend_i,
  input  logic signed [ACC_W-1:0] fb_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic signed [ACC_W-1:0] acc_next_o
);
  localparam int unsigned SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] MAX_V = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MIN_V = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q;
  logic signed [SUM_W-1:0] sum;
  sdm2_pkg::sat_e          sat;

  // Two extra bits hold any acc + addend - fb without overflow.
  always_comb begin
    sum = SUM_W'(acc_q) + SUM_W'(addend_i) - SUM_W'(fb_i);
    if (sum > MAX_V)      sat = sdm2_pkg::SAT_HIGH;
    else if (sum < MIN_V) sat = sdm2_pkg::SAT_LOW;
    else                  sat = sdm2_pkg::SAT_NONE;
  end

  always_comb begin
    case (sat)
      sdm2_pkg::SAT_HIGH: acc_next_o = MAX_V[ACC_W-1:0];
      sdm2_pkg::SAT_LOW:  acc_next_o = MIN_V[ACC_W-1:0];
      default:            acc_next_o = sum[ACC_W-1:0];
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (srst_i)    acc_q <= '0;
    else if (ce_i) acc_q <= acc_next_o;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/sdm2_quantizer.sv
module sdm2_quantizer #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned ACC_W = 20
) (
  input  logic                    clk_i,
  input  logic                    srst_i,
  input  logic                    ce_i,
  input  logic signed [ACC_W-1:0] level_i,
  output logic                    bit_o,
  output logic signed [ACC_W-1:0] fb_o
);
  localparam int unsigned GUARD = ACC_W - IN_W;
  localparam logic signed [ACC_W-1:0] FS_POS = {{GUARD{1'b0}}, 1'b1, {(IN_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] FS_NEG = {{GUARD{1'b1}}, 1'b1, {(IN_W-1){1'b0}}};

  logic bit_q;

  // A level of zero or above counts as a one.
  always_ff @(posedge clk_i) begin
    if (srst_i)    bit_q <= 1'b0;
    else if (ce_i) bit_q <= ~level_i[ACC_W-1];
  end

  assign bit_o = bit_q;
  assign fb_o  = bit_q ? FS_POS : FS_NEG;
endmodule

// File: rtl/sdm2_modulator.sv
module sdm2_modulator #(
  parameter int unsigned IN_W  = sdm2_pkg::DEF_IN_W,
  parameter int unsigned GUARD = sdm2_pkg::DEF_GUARD
) (
  input  logic                   clk_i,
  input  logic                   srst_i,
  input  logic                   ce_i,
  input  logic signed [IN_W-1:0] sample_i,
  output logic                   bit_o
);
  localparam int unsigned ACC_W = IN_W + GUARD;
  localparam int unsigned ORDER = 2;

  logic signed [ACC_W-1:0] sample_ext;
  logic signed [ACC_W-1:0] fb_s;
  logic signed [ACC_W-1:0] addend [ORDER];
  logic signed [ACC_W-1:0] acc_q  [ORDER];
  logic signed [ACC_W-1:0] acc_nx [ORDER];
  logic signed [ACC_W-1:0] acc1_q;
  logic signed [ACC_W-1:0] acc2_q;

  assign sample_ext = ACC_W'(sample_i);

  // Stage 0 integrates the input; later stages integrate the freshly
  // updated value of the stage before them. Every stage subtracts the
  // same fed-back decision.
  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign addend[k] = sample_ext;
    end else begin : g_tail
      assign addend[k] = acc_nx[k-1];
    end
    sdm2_integrator #(.ACC_W(ACC_W)) u_int (
      .clk_i      (clk_i),
      .srst_i     (srst_i),
      .ce_i       (ce_i),
      .addend_i   (addend[k]),
      .fb_i       (fb_s),
      .acc_o      (acc_q[k]),
      .acc_next_o (acc_nx[k])
    );
  end

  sdm2_quantizer #(.IN_W(IN_W), .ACC_W(ACC_W)) u_quant (
    .clk_i   (clk_i),
    .srst_i  (srst_i),
    .ce_i    (ce_i),
    .level_i (acc_nx[ORDER-1]),
    .bit_o   (bit_o),
    .fb_o    (fb_s)
  );

  assign acc1_q = acc_q[0];
  assign acc2_q = acc_q[1];
endmodule

// File: rtl/sdm2_checker.sv
module sdm2_checker #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned ACC_W = 20
) (
  input logic                    clk_i,
  input logic                    srst_i,
  input logic                    ce_i,
  input logic signed [IN_W-1:0]  sample_i,
  input logic signed [ACC_W-1:0] fb_i,
  input logic signed [ACC_W-1:0] acc1_i,
  input logic signed [ACC_W-1:0] acc2_i,
  input logic                    bit_i
);
  localparam int unsigned W2 = ACC_W + 2;
  logic signed [W2-1:0] in_step;
  logic signed [W2-1:0] acc1_w;
  logic signed [W2-1:0] fb_w;

  always_comb begin
    acc1_w  = W2'(acc1_i);
    fb_w    = W2'(fb_i);
    in_step = W2'(sample_i) - fb_w;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    srst_i |=> (!bit_i && acc1_i == '0 && acc2_i == '0)); // R7

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (srst_i)
    !ce_i |=> ($stable(bit_i) && $stable(acc1_i) && $stable(acc2_i))); // R8

  AST_NO_WRAP_FIRST: assert property (@(posedge clk_i) disable iff (srst_i)
    (ce_i && acc1_i >= 0 && in_step >= 0) |=> (acc1_i >= $past(acc1_i))); // R6

  AST_NO_WRAP_SECOND: assert property (@(posedge clk_i) disable iff (srst_i)
    (ce_i && acc2_i >= 0) |=> ((acc1_w - $past(fb_w)) < 0 || acc2_i >= $past(acc2_i))); // R6
endmodule

bind sdm2_modulator sdm2_checker #(.IN_W(IN_W), .ACC_W(ACC_W)) u_chk (
  .clk_i    (clk_i),
  .srst_i   (srst_i),
  .ce_i     (ce_i),
  .sample_i (sample_i),
  .fb_i     (fb_s),
  .acc1_i   (acc1_q),
  .acc2_i   (acc2_q),
  .bit_i    (bit_o)
);

// File: tb/tb_sdm2_modulator.sv
module tb_sdm2_modulator;
  logic               clk = 1'b0;
  logic               srst = 1'b1;
  logic               ce = 1'b0;
  logic signed [15:0] sample = '0;
  logic               bit_o;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sdm2_modulator dut (
    .clk_i(clk), .srst_i(srst), .ce_i(ce), .sample_i(sample), .bit_o(bit_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); srst = 1'b1; ce = 1'b0;
    @(negedge clk); srst = 1'b0;
  endtask

  task automatic grab4(output logic [3:0] bits);
    for (int i = 3; i >= 0; i--) begin
      @(negedge clk); bits[i] = bit_o;
    end
  endtask

  task automatic run_density(input logic signed [15:0] x, output int ones);
    do_reset();
    sample = x; ce = 1'b1;
    repeat (64) @(negedge clk);
    ones = 0;
    repeat (4096) begin
      @(negedge clk);
      if (bit_o) ones++;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(bit_o == 1'b0, "R7 reset state", int'(bit_o), 0);
  endtask

  task automatic t_startup();
    logic [3:0] b;
    do_reset();
    sample = 16'sd0; ce = 1'b1;
    grab4(b);
    chk(b == 4'b1101, "R1 start-up bits", int'(b), 13);
  endtask

  task automatic t_mid_densities();
    int z, p, n;
    run_density(16'sd0, z);
    chk(z >= 2028 && z <= 2068, "R2 zero density", z, 2048);
    run_density(16'sd20480, p);
    chk(p >= 3308 && p <= 3348, "R3 +0.625FS density", p, 3328);
    run_density(-16'sd20480, n);
    chk(n >= 748 && n <= 788, "R4 -0.625FS density", n, 768);
    chk(p + n >= 4080 && p + n <= 4112, "R4 symmetry", p + n, 4096);
  endtask

  task automatic t_full_scale();
    int p, n;
    run_density(16'sd32767, p);
    chk(p >= 4076, "R5 +FS density", p, 4096);
    chk(p == 4096, "R6 no wrap +FS", p, 4096);
    run_density(-16'sd32768, n);
    chk(n <= 20, "R5 -FS density", n, 0);
    chk(n == 0, "R6 no wrap -FS", n, 0);
  endtask

  task automatic t_hold();
    logic [3:0] b;
    int bad = 0;
    do_reset();
    sample = 16'sd0; ce = 1'b1;
    repeat (2) @(negedge clk);
    ce = 1'b0; sample = 16'sd32767;
    repeat (20) begin
      @(negedge clk);
      if (bit_o !== 1'b1) bad++;
    end
    chk(bad == 0, "R8 output held", bad, 0);
    sample = 16'sd0; ce = 1'b1;
    grab4(b);
    chk(b[3:2] == 2'b01, "R8 stream resumes", int'(b[3:2]), 1);
  endtask

  task automatic t_reset_mid();
    logic [3:0] b;
    do_reset();
    sample = 16'sd32767; ce = 1'b1;
    repeat (100) @(negedge clk);
    ce = 1'b0; srst = 1'b1;
    @(negedge clk);
    chk(bit_o == 1'b0, "R7 reset with ce low", int'(bit_o), 0);
    srst = 1'b0; sample = 16'sd0; ce = 1'b1;
    grab4(b);
    chk(b == 4'b1101, "R7 integrators cleared", int'(b), 13);
  endtask

  task automatic t_launch();
    logic a, c, prev;
    int bad = 0, toggles = 0;
    do_reset();
    sample = 16'sd20480; ce = 1'b1;
    prev = 1'b0;
    repeat (200) begin
      @(posedge clk);
      #2  a = bit_o;
      #16 c = bit_o;
      if (a !== c) bad++;
      if (a !== prev) toggles++;
      prev = a;
    end
    @(negedge clk);
    chk(bad == 0, "R9 stable between edges", bad, 0);
    chk(toggles > 0, "R9 bits launched", toggles, 1);
  endtask

  initial begin
    t_reset_state();
    t_startup();
    t_mid_densities();
    t_full_scale();
    t_hold();
    t_reset_mid();
    t_launch();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule